// File: doc/BRIEF.md
# Isochronous Audio Packet Header and Timestamp Generator

This block produces the two-quadlet common isochronous packet header that leads every outgoing audio packet. For each request it takes the number of events (sample frames) the packet will carry. It then returns the finished header one cycle later, together with the running data block count that follows the packet. The payload is filled elsewhere. Static configuration supplies the node ID, the channel count and a 3-bit sample-rate code.

The block also decides whether the packet carries a presentation timestamp. A timestamp is emitted only when one of the packet's events lands on a timestamp-interval boundary of the running data block count. The timestamp is taken from a 4-bit cycle counter and a 12-bit tick offset inside the cycle. Each emitted stamp moves the offset forward by the exact rational tick distance between two boundaries. That distance is held as an integer plus a remainder over the sample rate, so the offset does not drift. Offset overflow past 3072 ticks carries into the cycle counter. An external signed-free tick correction can be folded into the offset at any time, and a load strobe restarts the timing state with a fixed transfer delay.

Top module: `cip_header_gen`

## Requirements
- R1: Header quadlet 0 is, from bit 31 down: a 2-bit zero marker, source ID = nodeId[5:0] (6 bits), block size = dimension (8 bits), eight zero bits (fraction number, padding count, source-header flag, reserved), then the data block count before this packet (8 bits, bits 7:0).
- R2: Header quadlet 1 bits 31:24 read 0x90, which is a 2-bit marker of value 2 followed by the 6-bit format code 0x10.
- R3: Header quadlet 1 bits 23:16 carry the rate code zero-extended. The codes are 0=32 kHz, 1=44.1 kHz, 2=48 kHz, 3=88.2 kHz, 4=96 kHz, 5=176.4 kHz and 6=192 kHz; code 7 behaves as 0. The timestamp interval is 8 events for codes 0–2, 16 for codes 3–4 and 32 for codes 5–6.
- R4: A packet is stamped, with tsPresent=1, exactly when ((interval − dbc) mod 256) AND (interval − 1) is less than the packet's event count.
- R5: A stamped packet carries, in bits 15:0 of quadlet 1, {cycle[3:0], offset[11:0]}. An unstamped packet carries 0xFFFF there.
- R6: After each stamped packet the offset grows by floor(24,576,000·interval/rate) ticks. One further tick is added whenever a running remainder, stepped by (24,576,000·interval mod rate), reaches the rate. Whole units of 3072 ticks carry into the cycle counter, which wraps at 16. The offset always stays below 3072.
- R7: The data block count advances by the event count of every accepted packet, modulo 256. dbcOut shows the advanced value alongside the header.
- R8: When corrValid is high, corrTicks is added to the offset with the same 3072 carry. If this coincides with a stamped packet, that packet's stamp uses the values from before both additions, and both additions take effect.
- R9: Reset or cfgLoad sets cycle=2, offset=2856 (a 9000-tick delay) and remainder=0, and clears the data block count. While cfgLoad is high, reqReady is low and corrections are ignored.
- R10: A request is accepted when reqValid and reqReady are both high. hdrValid pulses for one cycle in the following cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Restart timing state and data block count |
| nodeId | input | 16 | Local node ID; low 6 bits used as source ID |
| dimension | input | 8 | Channels per event |
| rateCode | input | 3 | Sample-rate code |
| reqValid | input | 1 | Header request valid |
| reqReady | output | 1 | Request can be accepted |
| reqEvents | input | 8 | Events in the requested packet |
| corrValid | input | 1 | Apply tick correction this cycle |
| corrTicks | input | 12 | Tick correction amount |
| hdrValid | output | 1 | Header outputs valid |
| hdrQ0 | output | 32 | Header quadlet 0 |
| hdrQ1 | output | 32 | Header quadlet 1 |
| tsPresent | output | 1 | Packet carries a timestamp |
| dbcOut | output | 8 | Data block count after this packet |

## Verification
The interesting collision is a tick correction arriving in the same cycle as a request whose packet is stamped. In that case two increments, and possibly a remainder carry tick, meet in one offset sum that may cross 3072 more than once. The random phase raises corrValid on roughly a third of cycles regardless of requests, so this coincidence happens many times at every rate. It is judged through later stamps: a reference model applies both additions and the carry, and each subsequent timestamp must equal the model's {cycle, offset}.

// File: rtl/cip_pkg.sv
package cip_pkg;

  typedef struct packed {
    logic load;       // restart timing state
    logic accept;     // request taken this cycle
    logic applyCorr;  // fold correction into offset
  } cip_strobe_t;

  typedef struct packed {
    logic [17:0] rateHz;
    logic [5:0]  interval;
    logic [12:0] tickInt;
    logic [17:0] tickRem;
  } rate_info_t;

  // tick step = 24576000 * interval / rate, split into integer and remainder
  function automatic rate_info_t rateInfo(input logic [2:0] code);
    rate_info_t r;
    case (code)
      3'd1:    r = '{rateHz: 18'd44100,  interval: 6'd8,  tickInt: 13'd4458, tickRem: 18'd10200};
      3'd2:    r = '{rateHz: 18'd48000,  interval: 6'd8,  tickInt: 13'd4096, tickRem: 18'd0};
      3'd3:    r = '{rateHz: 18'd88200,  interval: 6'd16, tickInt: 13'd4458, tickRem: 18'd20400};
      3'd4:    r = '{rateHz: 18'd96000,  interval: 6'd16, tickInt: 13'd4096, tickRem: 18'd0};
      3'd5:    r = '{rateHz: 18'd176400, interval: 6'd32, tickInt: 13'd4458, tickRem: 18'd40800};
      3'd6:    r = '{rateHz: 18'd192000, interval: 6'd32, tickInt: 13'd4096, tickRem: 18'd0};
      default: r = '{rateHz: 18'd32000,  interval: 6'd8,  tickInt: 13'd6144, tickRem: 18'd0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cip_ctrl.sv
module cip_ctrl
  import cip_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgLoad,
  input  logic        reqValid,
  input  logic        corrValid,
  output logic        reqReady,
  output cip_strobe_t strobe,
  output logic        hdrValid
);

  // a restart cycle owns the timing state, so nothing else is taken then
  always_comb begin
    reqReady         = !cfgLoad;
    strobe.load      = cfgLoad;
    strobe.accept    = reqValid && !cfgLoad;
    strobe.applyCorr = corrValid && !cfgLoad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hdrValid <= 1'b0;
    else        hdrValid <= strobe.accept;
  end

endmodule

// File: rtl/cip_datapath.sv
module cip_datapath
  import cip_pkg::*;
#(
  parameter int DBC_W    = 8,
  parameter int CYC_W    = 4,
  parameter int OFF_W    = 12,
  parameter int CORR_W   = 12,
  parameter int TPC      = 3072,
  parameter int DELAY    = 9000,
  parameter int NODE_W   = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  cip_strobe_t       strobe,
  input  logic [NODE_W-1:0] nodeId,
  input  logic [7:0]        dimension,
  input  logic [2:0]        rateCode,
  input  logic [DBC_W-1:0]  reqEvents,
  input  logic [CORR_W-1:0] corrTicks,
  output logic [31:0]       hdrQ0,
  output logic [31:0]       hdrQ1,
  output logic              tsPresent,
  output logic [DBC_W-1:0]  dbcOut
);

  localparam int SUM_W     = OFF_W + 3;
  localparam int MAX_CARRY = ((TPC - 1) + 8192 + (1 << CORR_W)) / TPC + 1;
  localparam logic [CYC_W-1:0] CYC_INIT = CYC_W'(DELAY / TPC);
  localparam logic [OFF_W-1:0] OFF_INIT = OFF_W'(DELAY % TPC);
  localparam logic [SUM_W-1:0] TPC_S    = SUM_W'(TPC);

  logic [DBC_W-1:0] dbcReg;
  logic [CYC_W-1:0] cycReg;
  logic [OFF_W-1:0] offReg;
  logic [17:0]      remReg;

  rate_info_t       info;
  logic [DBC_W-1:0] ivl, tsIdx;
  logic             tsHit;
  logic [15:0]      sytVal;
  logic [18:0]      remSum;
  logic             remWrap;
  logic [17:0]      remNext;
  logic [SUM_W-1:0] offSum, offRed;
  logic [CYC_W-1:0] carryCnt;
  logic             stepTs, touchOff;

  always_comb begin
    info    = rateInfo(rateCode);
    ivl     = DBC_W'(info.interval);
    tsIdx   = (ivl - dbcReg) & (ivl - DBC_W'(1));
    tsHit   = tsIdx < reqEvents;
    sytVal  = tsHit ? {cycReg, offReg} : 16'hFFFF;
    stepTs  = strobe.accept && tsHit;

    remSum  = {1'b0, remReg} + {1'b0, info.tickRem};
    remWrap = remSum >= {1'b0, info.rateHz};
    remNext = remWrap ? 18'(remSum - {1'b0, info.rateHz}) : remSum[17:0];

    offSum = SUM_W'(offReg);
    if (stepTs)           offSum = offSum + SUM_W'(info.tickInt) + SUM_W'(remWrap);
    if (strobe.applyCorr) offSum = offSum + SUM_W'(corrTicks);
    touchOff = stepTs || strobe.applyCorr;

    offRed   = offSum;
    carryCnt = '0;
    for (int k = 0; k < MAX_CARRY; k++) begin
      if (offRed >= TPC_S) begin
        offRed   = offRed - TPC_S;
        carryCnt = carryCnt + CYC_W'(1);
      end
    end
  end

  // timing state
  always_ff @(posedge clk) begin
    if (!rst_n || strobe.load) begin
      dbcReg <= '0;
      cycReg <= CYC_INIT;
      offReg <= OFF_INIT;
      remReg <= '0;
    end else begin
      if (strobe.accept) dbcReg <= dbcReg + reqEvents;
      if (stepTs)        remReg <= remNext;
      if (touchOff) begin
        cycReg <= cycReg + carryCnt;
        offReg <= offRed[OFF_W-1:0];
      end
    end
  end

  // header registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdrQ0     <= '0;
      hdrQ1     <= '0;
      tsPresent <= 1'b0;
      dbcOut    <= '0;
    end else if (strobe.accept) begin
      hdrQ0     <= {2'b00, nodeId[5:0], dimension, 8'h00, dbcReg};
      hdrQ1     <= {2'b10, 6'h10, 5'b00000, rateCode, sytVal};
      tsPresent <= tsHit;
      dbcOut    <= dbcReg + reqEvents;
    end
  end

endmodule

// File: rtl/cip_header_gen.sv
module cip_header_gen
  import cip_pkg::*;
#(
  parameter int DBC_W  = 8,
  parameter int CORR_W = 12,
  parameter int NODE_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgLoad,
  input  logic [NODE_W-1:0] nodeId,
  input  logic [7:0]        dimension,
  input  logic [2:0]        rateCode,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [DBC_W-1:0]  reqEvents,
  input  logic              corrValid,
  input  logic [CORR_W-1:0] corrTicks,
  output logic              hdrValid,
  output logic [31:0]       hdrQ0,
  output logic [31:0]       hdrQ1,
  output logic              tsPresent,
  output logic [DBC_W-1:0]  dbcOut
);

  cip_strobe_t strobe;

  cip_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgLoad   (cfgLoad),
    .reqValid  (reqValid),
    .corrValid (corrValid),
    .reqReady  (reqReady),
    .strobe    (strobe),
    .hdrValid  (hdrValid)
  );

  cip_datapath #(
    .DBC_W  (DBC_W),
    .CORR_W (CORR_W),
    .NODE_W (NODE_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .nodeId    (nodeId),
    .dimension (dimension),
    .rateCode  (rateCode),
    .reqEvents (reqEvents),
    .corrTicks (corrTicks),
    .hdrQ0     (hdrQ0),
    .hdrQ1     (hdrQ1),
    .tsPresent (tsPresent),
    .dbcOut    (dbcOut)
  );

endmodule

// File: rtl/cip_header_gen_chk.sv
module cip_header_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        reqReady,
  input logic [7:0]  reqEvents,
  input logic        hdrValid,
  input logic [31:0] hdrQ0,
  input logic [31:0] hdrQ1,
  input logic        tsPresent,
  input logic [7:0]  dbcOut
);

  assert_hdr_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> hdrValid);

  assert_no_spurious_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reqValid && reqReady) |=> !hdrValid);

  assert_q0_zero_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |-> (hdrQ0[31:30] == 2'b00 && hdrQ0[15:8] == 8'h00));

  assert_q1_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |-> hdrQ1[31:24] == 8'h90);

  assert_fdf_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |-> hdrQ1[23:19] == 5'b00000);

  assert_empty_stamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdrValid && !tsPresent) |-> hdrQ1[15:0] == 16'hFFFF);

  assert_offset_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdrValid && tsPresent) |-> hdrQ1[11:0] < 12'd3072);

  assert_dbc_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |-> dbcOut == 8'(hdrQ0[7:0] + $past(reqEvents)));

endmodule

bind cip_header_gen cip_header_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqEvents (reqEvents),
  .hdrValid  (hdrValid),
  .hdrQ0     (hdrQ0),
  .hdrQ1     (hdrQ1),
  .tsPresent (tsPresent),
  .dbcOut    (dbcOut)
);

// File: tb/cip_header_gen_tb.sv
`timescale 1ns/1ps
module cip_header_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [15:0] nodeId = 16'h0000;
  logic [7:0]  dimension = 8'd2;
  logic [2:0]  rateCode = 3'd2;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqEvents = 8'd0;
  logic        corrValid = 1'b0;
  logic [11:0] corrTicks = 12'd0;
  logic        hdrValid;
  logic [31:0] hdrQ0, hdrQ1;
  logic        tsPresent;
  logic [7:0]  dbcOut;

  int checks = 0;
  int errors = 0;

  // reference state
  int mCyc, mOff, mRem, mDbc;

  always #2.5 clk = ~clk;

  cip_header_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfgLoad(cfgLoad), .nodeId(nodeId),
    .dimension(dimension), .rateCode(rateCode), .reqValid(reqValid),
    .reqReady(reqReady), .reqEvents(reqEvents), .corrValid(corrValid),
    .corrTicks(corrTicks), .hdrValid(hdrValid), .hdrQ0(hdrQ0), .hdrQ1(hdrQ1),
    .tsPresent(tsPresent), .dbcOut(dbcOut)
  );

  function automatic int rateOf(input int c);
    case (c)
      1: return 44100; 2: return 48000; 3: return 88200;
      4: return 96000; 5: return 176400; 6: return 192000;
      default: return 32000;
    endcase
  endfunction

  function automatic int ivlOf(input int c);
    if (c == 3 || c == 4) return 16;
    if (c == 5 || c == 6) return 32;
    return 8;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelInit();
    mCyc = 2; mOff = 2856; mRem = 0; mDbc = 0;
  endtask

  // one cycle: drive at negedge, check at the next negedge, update model
  task automatic cycle(input bit v, input int ev, input bit ld, input bit cv, input int corr);
    int iv, rate, ti, tr, idx, add, rs;
    bit hit, acc;
    logic [15:0] syt;
    logic [31:0] eq0, eq1;
    reqValid = v; reqEvents = 8'(ev); cfgLoad = ld; corrValid = cv; corrTicks = 12'(corr);
    #0.1;
    check(reqReady == !ld, "R9", "reqReady", 32'(reqReady), 32'(!ld));
    iv   = ivlOf(int'(rateCode));
    rate = rateOf(int'(rateCode));
    ti   = (24576000 * iv) / rate;
    tr   = (24576000 * iv) % rate;
    idx  = ((iv - mDbc) & 255) & (iv - 1);
    acc  = v && !ld;
    hit  = idx < ev;
    syt  = hit ? 16'(((mCyc & 15) << 12) | mOff) : 16'hFFFF;
    eq0  = {2'b00, nodeId[5:0], dimension, 8'h00, 8'(mDbc)};
    eq1  = {8'h90, 5'b0, rateCode, syt};
    @(negedge clk);
    check(hdrValid == acc, "R10", "hdrValid", 32'(hdrValid), 32'(acc));
    if (acc) begin
      check(hdrQ0 == eq0, "R1", "quadlet0", hdrQ0, eq0);
      check(hdrQ1[31:16] == eq1[31:16], "R2/R3", "quadlet1 high", 32'(hdrQ1[31:16]), 32'(eq1[31:16]));
      check(tsPresent == hit, "R4", "tsPresent", 32'(tsPresent), 32'(hit));
      check(hdrQ1[15:0] == syt, "R5/R6/R8", "timestamp", 32'(hdrQ1[15:0]), 32'(syt));
      check(dbcOut == 8'(mDbc + ev), "R7", "dbcOut", 32'(dbcOut), 32'((mDbc + ev) & 255));
    end
    if (ld) modelInit();
    else begin
      add = 0;
      if (acc) mDbc = (mDbc + ev) & 255;
      if (acc && hit) begin
        rs = mRem + tr;
        if (rs >= rate) begin rs = rs - rate; add = 1; end
        mRem = rs;
        add  = add + ti;
      end
      if (cv) add = add + corr;
      mOff = mOff + add;
      mCyc = (mCyc + mOff / 3072) & 15;
      mOff = mOff % 3072;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    modelInit();
    repeat (3) @(negedge clk);
    // reset state (R10, R9)
    check(hdrValid == 1'b0, "R10", "reset hdrValid", 32'(hdrValid), 0);
    check(hdrQ0 == 32'd0 && dbcOut == 8'd0, "R9", "reset outputs", hdrQ0, 0);
    rst_n = 1'b1;
    nodeId = 16'hFFC5; dimension = 8'd2; rateCode = 3'd2;

    // directed: first stamp after reset at 48 kHz is {2, 2856} (R9)
    cycle(1, 8, 0, 0, 0);
    check(hdrQ1[15:0] == 16'h2B28, "R9", "first stamp", 32'(hdrQ1[15:0]), 32'h2B28);
    // second stamp: 2856+4096 = 6952 -> cycle 4, offset 808 (R6)
    cycle(1, 8, 0, 0, 0);
    check(hdrQ1[15:0] == 16'h4328, "R6", "second stamp", 32'(hdrQ1[15:0]), 32'h4328);
    // non-boundary packet: events 3 at dbc 16 -> idx 0, stamped; then dbc 19 events 3 -> idx 5, not stamped (R4)
    cycle(1, 3, 0, 0, 0);
    cycle(1, 3, 0, 0, 0);
    check(tsPresent == 1'b0, "R4", "unstamped packet", 32'(tsPresent), 0);
    // correction alone then a stamp reveals it (R8)
    cycle(0, 0, 0, 1, 4000);
    cycle(1, 8, 0, 0, 0);
    // correction coinciding with a stamped packet (R8)
    cycle(1, 8, 0, 1, 4095);
    cycle(1, 8, 0, 0, 0);
    // request during load is not taken, correction ignored (R9, R10)
    cycle(1, 8, 1, 1, 100);
    cycle(1, 8, 0, 0, 0);
    check(hdrQ1[15:0] == 16'h2B28, "R9", "stamp after load", 32'(hdrQ1[15:0]), 32'h2B28);
    // dbc wrap with large counts (R7)
    cycle(1, 255, 0, 0, 0);
    cycle(1, 200, 0, 0, 0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      int iv, ev, mode;
      bit ld;
      ld = ($urandom_range(0, 299) == 0);
      if (ld) begin
        rateCode  = 3'($urandom_range(0, 7));
        dimension = 8'($urandom_range(1, 16));
        nodeId    = 16'($urandom);
      end
      iv   = ivlOf(int'(rateCode));
      mode = $urandom_range(0, 9);
      if (mode < 4)      ev = $urandom_range(0, 2 * iv + 1);
      else if (mode < 7) ev = ($urandom_range(0, 1) != 0) ? iv : 0;
      else if (mode < 9) ev = $urandom_range(iv - 1, iv + 1);
      else               ev = $urandom_range(0, 255);
      cycle($urandom_range(0, 3) != 0, ev, ld, $urandom_range(0, 2) == 0,
            ($urandom_range(0, 3) == 0) ? 4095 : $urandom_range(0, 4095));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule